// File: doc/BRIEF.md
# Four-Channel External Pin Interrupt Sense Unit

This block watches four input pins and turns activity on them into interrupt requests. Each channel has a 2-bit sense code chosen by software. The code selects one of four conditions: a held low level, any change, a falling edge or a rising edge. Each pin first passes through a two-flop synchroniser. Edges are then found by comparing consecutive synchronised samples. The unit reacts to the pin value whatever the pin's direction, so software can raise an interrupt by driving a pin that is configured as an output.

In the three edge modes a qualifying edge sets a per-channel pending flag. The flag holds until that channel's acknowledge pulse clears it. In low-level mode nothing is latched: the request simply follows the synchronised pin. A channel's request appears on `req_o` only when its mask bit and the global enable input are both set. `irq_o` combines all channel requests. Software reaches two 8-bit registers through a simple write strobe and an address bit: the sense-control register and the mask register.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Address 0 selects the sense register. Channel n uses bits [2n+1:2n], so channel 0 is bits 1:0 and channel 3 is bits 7:6. Address 1 selects the mask register, where bit n enables channel n. `reg_rdata` returns the register selected by `reg_addr` with no delay.
- R2: With sense code 00, `req_o[n]` is high while the synchronised pin is low and drops once the pin is back high. No pending state is kept.
- R3: With sense code 01, both a rising and a falling edge of the pin set the pending flag.
- R4: With sense code 10, only a falling edge sets the pending flag.
- R5: With sense code 11, only a rising edge sets the pending flag.
- R6: A pending flag holds until `ack_i[n]` is high at a clock edge. If a new qualifying edge arrives at the same edge as the acknowledge, the flag stays set.
- R7: `req_o[n]` is high only when mask bit n and `gie_i` are both high. A pending flag is still latched while its channel is masked or the global enable is low, and it appears once both are high.
- R8: Mask register bits 7:4 always read as zero, and writes to them have no effect.
- R9: After reset, both registers read zero and `req_o` and `irq_o` are low.
- R10: A write to the sense register that changes a channel's code clears that channel's pending flag. An edge that coincides with the write is discarded.
- R11: `irq_o` is the OR of the four `req_o` bits.
- R12: Each of the two synchroniser stages adds one cycle. A pin level held for one full clock period is therefore seen. A level request appears two edges after the pin changes, and a pending flag three edges after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Monitored pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = sense register, 1 = mask register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ack_i | input | 4 | Per-channel pending clear |
| req_o | output | 4 | Per-channel masked requests |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is several things meeting at one clock edge: a pin edge arriving together with an acknowledge, or together with a sense-code rewrite. The random phase drives pins, acknowledges, register writes and the global enable every cycle from a seeded generator, so these coincidences happen many times. A cycle-accurate bench model, built from the requirements, predicts `req_o` on every cycle. Directed cases cover the one-cycle pulse, retention of a flag while its channel is masked, and the clear on a mode change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned FIELD_W = 2;
  typedef enum logic [FIELD_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  localparam int unsigned REG_W = NCH * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] sense_o,
  output logic [NCH-1:0]   mask_o,
  output logic [NCH-1:0]   mode_chg_o
);
  logic [REG_W-1:0] sense_q, sense_d;
  logic [NCH-1:0]   mask_q, mask_d;
  logic             sense_we, mask_we;

  assign sense_we = wr_en && (addr == 1'b0);
  assign mask_we  = wr_en && (addr == 1'b1);

  always_comb begin
    sense_d = sense_q;
    mask_d  = mask_q;
    if (sense_we) sense_d = wdata;
    if (mask_we)  mask_d  = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else begin
      sense_q <= sense_d;
      mask_q  <= mask_d;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chg
      assign mode_chg_o[c] = sense_we &&
        (wdata[c*FIELD_W +: FIELD_W] != sense_q[c*FIELD_W +: FIELD_W]);
    end
  endgenerate

  assign rdata   = addr ? {{(REG_W-NCH){1'b0}}, mask_q} : sense_q;
  assign sense_o = sense_q;
  assign mask_o  = mask_q;

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> (rdata[REG_W-1:NCH] == '0));
  assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_o == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_i,
  input  logic [FIELD_W-1:0] mode_i,
  input  logic               mode_chg_i,
  input  logic               ack_i,
  input  logic               en_i,
  output logic               req_o
);
  sense_e mode;
  logic   prev_q, pend_q, pend_d;
  logic   rise, fall, hit;

  assign mode = sense_e'(mode_i);
  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    unique case (mode)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (mode == SENSE_LOW) pend_d = 1'b0;
    else if (mode_chg_i)   pend_d = 1'b0;
    else if (hit)          pend_d = 1'b1;
    else if (ack_i)        pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      pend_q <= pend_d;
    end
  end

  assign req_o = en_i & ((mode == SENSE_LOW) ? ~smp_i : pend_q);

  assert_level_unlatched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW) |-> !pend_q);
  assert_pend_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(mode) != SENSE_LOW) && !$past(mode_chg_i));
  assert_pend_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> ($past(ack_i) || $past(mode_chg_i) || $past(mode) == SENSE_LOW));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned SYNC_LEN = 2,
  localparam int unsigned REG_W   = NCH * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pin_i,
  input  logic             gie_i,
  input  logic             reg_wr_en,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   ack_i,
  output logic [NCH-1:0]   req_o,
  output logic             irq_o
);
  logic [NCH-1:0]   smp;
  logic [REG_W-1:0] sense;
  logic [NCH-1:0]   mask;
  logic [NCH-1:0]   mode_chg;

  ext_irq_sync #(.WIDTH(NCH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(smp)
  );

  ext_irq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .sense_o(sense),
    .mask_o(mask), .mode_chg_o(mode_chg)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ext_irq_chan u_chan (
        .clk(clk), .rst_n(rst_n), .smp_i(smp[c]),
        .mode_i(sense[c*FIELD_W +: FIELD_W]), .mode_chg_i(mode_chg[c]),
        .ack_i(ack_i[c]), .en_i(mask[c] & gie_i), .req_o(req_o[c])
      );
    end
  endgenerate

  assign irq_o = |req_o;

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & ~mask) == '0) && (gie_i || req_o == '0));
  assert_irq_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_o != '0));
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_i = 4'hF;
  logic       gie_i = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] ack_i = 4'h0;
  logic [3:0] req_o;
  logic       irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_i(ack_i), .req_o(req_o), .irq_o(irq_o)
  );

  // Reference model built from the requirements
  logic [3:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  logic [7:0] m_sense;

  function automatic logic [3:0] exp_req();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) begin
      logic lvl;
      lvl  = (m_sense[2*c +: 2] == 2'b00) ? ~m_s2[c] : m_pend[c];
      r[c] = lvl & m_mask[c] & gie_i;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
      m_mask <= '0; m_sense <= '0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] md;
        logic rs, fl, ht, chg;
        md  = m_sense[2*c +: 2];
        rs  = m_s2[c] & ~m_prev[c];
        fl  = ~m_s2[c] & m_prev[c];
        ht  = (md == 2'b01) ? (rs | fl) : (md == 2'b10) ? fl : (md == 2'b11) ? rs : 1'b0;
        chg = reg_wr_en && !reg_addr && (reg_wdata[2*c +: 2] != md);
        if (md == 2'b00 || chg) m_pend[c] <= 1'b0;
        else if (ht)            m_pend[c] <= 1'b1;
        else if (ack_i[c])      m_pend[c] <= 1'b0;
      end
      m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (reg_wr_en && !reg_addr) m_sense <= reg_wdata;
      if (reg_wr_en &&  reg_addr) m_mask  <= reg_wdata[3:0];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    tick(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic a, input logic [7:0] e, input string req);
    reg_addr = a; #1;
    check(reg_rdata == e, req, reg_rdata, e);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R9 reset state
    check(req_o == 4'h0 && irq_o == 1'b0, "R9", {irq_o, req_o}, 0);
    rd_check(1'b0, 8'h00, "R9");
    rd_check(1'b1, 8'h00, "R9");
    // R8 reserved mask bits, R1 field layout readback
    wr(1'b1, 8'hFF);
    rd_check(1'b1, 8'h0F, "R8");
    wr(1'b0, 8'hE4); // ch0=low ch1=any ch2=fall ch3=rise
    rd_check(1'b0, 8'hE4, "R1");
    gie_i = 1'b1;
    tick(3);
    check(req_o == 4'h0, "R1", req_o, 0);
    // R2 level mode, R12 latency
    pin_i[0] = 1'b0; tick(1);
    check(req_o[0] == 1'b0, "R12", req_o[0], 0);
    tick(1);
    check(req_o[0] == 1'b1, "R2", req_o[0], 1);
    pin_i[0] = 1'b1; tick(2);
    check(req_o[0] == 1'b0, "R2", req_o[0], 0);
    // R5 rising only on ch3
    pin_i[3] = 1'b0; tick(3);
    check(req_o[3] == 1'b0, "R5", req_o[3], 0);
    pin_i[3] = 1'b1; tick(2);
    check(req_o[3] == 1'b0, "R12", req_o[3], 0);
    tick(1);
    check(req_o[3] == 1'b1, "R5", req_o[3], 1);
    check(irq_o == 1'b1, "R11", irq_o, 1);
    tick(4);
    check(req_o[3] == 1'b1, "R6", req_o[3], 1);
    ack_i[3] = 1'b1; tick(1); ack_i[3] = 1'b0;
    check(req_o[3] == 1'b0 && irq_o == 1'b0, "R6", {irq_o, req_o}, 0);
    // R4 falling on ch2
    pin_i[2] = 1'b0; tick(3);
    check(req_o[2] == 1'b1, "R4", req_o[2], 1);
    // R7 global enable gates, flag retained
    gie_i = 1'b0; #1;
    check(req_o == 4'h0 && irq_o == 1'b0, "R7", req_o, 0);
    tick(2); gie_i = 1'b1; #1;
    check(req_o[2] == 1'b1, "R7", req_o[2], 1);
    ack_i = 4'hF; tick(1); ack_i = 4'h0;
    // R3 + R12: single-cycle pulse on ch1 (any change)
    pin_i[1] = 1'b0; tick(1); pin_i[1] = 1'b1; tick(4);
    check(req_o[1] == 1'b1, "R3", req_o[1], 1);
    ack_i[1] = 1'b1; tick(1); ack_i[1] = 1'b0; tick(3);
    check(req_o[1] == 1'b0, "R6", req_o[1], 0);
    // R7 masked channel still latches
    wr(1'b1, 8'h0D);
    pin_i[1] = 1'b0; tick(4);
    check(req_o[1] == 1'b0, "R7", req_o[1], 0);
    wr(1'b1, 8'h0F);
    check(req_o[1] == 1'b1, "R7", req_o[1], 1);
    ack_i[1] = 1'b1; tick(1); ack_i[1] = 1'b0;
    // R10 mode change clears pending on ch2
    pin_i[2] = 1'b1; tick(3); pin_i[2] = 1'b0; tick(4);
    check(req_o[2] == 1'b1, "R10", req_o[2], 1);
    wr(1'b0, 8'hF4);
    check(req_o[2] == 1'b0, "R10", req_o[2], 0);
    // Random phase against model (all requirements, R6 and R10 coincidences)
    for (int i = 0; i < 4000; i++) begin
      pin_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : pin_i;
      ack_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 15) == 0) gie_i = ~gie_i;
      if ($urandom_range(0, 9) == 0) begin
        reg_addr = 1'($urandom); reg_wdata = 8'($urandom); reg_wr_en = 1'b1;
      end else reg_wr_en = 1'b0;
      #1;
      check(req_o == exp_req(), "R6", req_o, exp_req());
      check(irq_o == |req_o, "R11", irq_o, |req_o);
      tick(1);
    end
    reg_wr_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule